// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock time and date as packed BCD values: seconds, minutes, hours, day of month, month, a two-digit year (2000 to 2099), and a day-of-week count. A low-rate tick enable (nominally 32768 per second) drives a prescaler. Each time the prescaler wraps, the calendar advances by one second. Carries move up through the fields, and the day field follows the length of the current month, including leap years.

Software uses a byte-wide register port. It can read every field and control bit at any time. It can load the time fields only while the clock is stopped. A busy flag is raised during the final tick interval before each update, so software knows when not to sample. Four sticky event flags record second, minute, hour and day rollovers, and each is cleared by writing a 1 to it. The second flag can also drive a level interrupt line.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, day 01, month 01, year 00 and weekday 00. Control reads 0x00 (stopped), status reads 0x00 and `irq_timer` is low.
- R2: The register map is: 0x0 seconds, 0x1 minutes, 0x2 hours, 0x3 day, 0x4 month, 0x5 year, 0x6 weekday, 0x8 control, 0x9 status and 0xA interrupt enable. With control bit 0 (run) set, the seconds field advances once every 2^PRESCALE_BITS asserted `tick_en` cycles. While run is clear, ticks are ignored and no field changes.
- R3: Seconds and minutes count 00 to 59 in BCD and wrap to 00. Each wrap increments the next field. Hours count 00 to 23, and a wrap increments the day.
- R4: The day wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. In month 02 it wraps after 29 when the year is divisible by 4 (including 00) and after 28 otherwise. Month wraps from 12 to 01 and increments the year. Year wraps from 99 to 00.
- R5: The weekday field counts 00 to 06. It advances on every day rollover and wraps from 06 to 00.
- R6: Status bit 0 (busy) is high only while the clock is running and the next asserted `tick_en` will perform the one-second update. Status bit 1 mirrors the run bit.
- R7: Status bits 2, 3, 4 and 5 are set on the second, minute, hour and day rollover events respectively. They stay set until software writes 1 to that bit position. Writing 0 to a bit leaves it unchanged.
- R8: `irq_timer` is high exactly when interrupt-enable bit 0 is set and status bit 2 is set.
- R9: A write to a time field (0x0 to 0x6) while stopped loads the written byte. The same write while running is ignored.
- R10: Control bit 1 (hour-format select) is stored and reads back. Hours always count in 24-hour form whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle enable per oscillator period |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_addr | input | ADDR_W | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_timer | output | 1 | Once-per-second interrupt level |

## Verification
The bench builds the core with PRESCALE_BITS set to 2, so one second takes four ticks. This lets every rollover path, including month ends, leap and non-leap Februaries, and the year wrap, be reached by loading a field set and running a single second. The small prescaler also places the busy window three ticks into each second, so its edges can be observed directly, along with the effect of stopping the clock on the tick count.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
   localparam int NUM_FIELDS = 7;
   localparam int IDX_SEC  = 0;
   localparam int IDX_MIN  = 1;
   localparam int IDX_HOUR = 2;
   localparam int IDX_DAY  = 3;
   localparam int IDX_MON  = 4;
   localparam int IDX_YEAR = 5;
   localparam int IDX_WDAY = 6;

   localparam int REG_CTRL = 8;
   localparam int REG_STAT = 9;
   localparam int REG_IEN  = 10;

   typedef logic [7:0] bcd_t;

   localparam bcd_t FIELD_MAX [NUM_FIELDS] = '{8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h06};
   localparam bcd_t FIELD_MIN [NUM_FIELDS] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00};

   function automatic bcd_t bcd_inc(input bcd_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic year_is_leap(input bcd_t y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic bcd_t last_day(input bcd_t mon, input bcd_t yr);
      case (mon)
         8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
   parameter int PRESCALE_BITS = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick_en,
   output logic busy,
   output logic sec_pulse
);
   localparam logic [PRESCALE_BITS-1:0] CNT_LAST = '1;

   generate
      if (PRESCALE_BITS < 1 || PRESCALE_BITS > 24) begin : g_bad_width
         $error("rtc_prescaler: PRESCALE_BITS out of range");
      end
   endgenerate

   logic [PRESCALE_BITS-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (run && tick_en) cnt_q <= cnt_q + 1'b1;
   end

   assign busy      = run && (cnt_q == CNT_LAST);
   assign sec_pulse = busy && tick_en;

   // R2: the divider holds whenever no counted tick arrives
   p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && tick_en) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_bcd_field.sv
`timescale 1ns/1ps
module rtc_bcd_field #(
   parameter logic [7:0] MIN_VAL = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       load,
   input  logic [7:0] ld_val,
   input  logic [7:0] wrap_at,
   output logic [7:0] val
);
   import rtc_cal_pkg::*;

   logic [7:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= MIN_VAL;
      else if (load) val_q <= ld_val;
      else if (inc) val_q <= (val_q >= wrap_at) ? MIN_VAL : bcd_inc(val_q);
   end

   assign val = val_q;

   // R3: a counted step at the top of the range lands on the field minimum
   p_wrap_to_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && val_q >= wrap_at) |=> (val_q == MIN_VAL));

   // R2: without a step or a load the field is frozen
   p_field_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !load) |=> $stable(val_q));
endmodule

// File: rtl/bcd_rtc_core.sv
`timescale 1ns/1ps
module bcd_rtc_core #(
   parameter int PRESCALE_BITS = 15,
   parameter int ADDR_W        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_timer
);
   import rtc_cal_pkg::*;

   localparam int EVT_N = 4;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("bcd_rtc_core: ADDR_W must reach the interrupt-enable index");
      end
   endgenerate

   logic       run_q, h12_q, ien_q;
   logic [EVT_N-1:0] evt_q;
   logic       busy, sec_pulse;
   logic       wr_hit;
   logic [7:0] vals    [NUM_FIELDS];
   logic [7:0] wrap_at [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] at_max;
   logic [NUM_FIELDS-1:0] inc_v;
   logic [NUM_FIELDS-1:0] load_v;
   logic [EVT_N-1:0] evt_set, evt_clr;

   assign wr_hit = bus_sel && bus_wr;

   rtc_prescaler #(.PRESCALE_BITS(PRESCALE_BITS)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_q),
      .tick_en   (tick_en),
      .busy      (busy),
      .sec_pulse (sec_pulse)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
         if (gi == IDX_DAY) begin : g_wrap_dyn
            assign wrap_at[gi] = last_day(vals[IDX_MON], vals[IDX_YEAR]);
         end else begin : g_wrap_fix
            assign wrap_at[gi] = FIELD_MAX[gi];
         end

         assign at_max[gi] = (vals[gi] >= wrap_at[gi]);
         assign load_v[gi] = wr_hit && !run_q && (bus_addr == ADDR_W'(gi));

         if (gi == 0) begin : g_inc_first
            assign inc_v[gi] = sec_pulse;
         end else if (gi == IDX_WDAY) begin : g_inc_wday
            assign inc_v[gi] = sec_pulse && (&at_max[IDX_HOUR:0]);
         end else begin : g_inc_chain
            assign inc_v[gi] = sec_pulse && (&at_max[gi-1:0]);
         end

         rtc_bcd_field #(.MIN_VAL(FIELD_MIN[gi])) u_fld (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (inc_v[gi]),
            .load    (load_v[gi]),
            .ld_val  (bus_wdata),
            .wrap_at (wrap_at[gi]),
            .val     (vals[gi])
         );
      end
   endgenerate

   assign evt_set = {inc_v[IDX_DAY], inc_v[IDX_HOUR], inc_v[IDX_MIN], sec_pulse};
   assign evt_clr = (wr_hit && bus_addr == ADDR_W'(REG_STAT)) ? bus_wdata[5:2] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         h12_q <= 1'b0;
         ien_q <= 1'b0;
         evt_q <= '0;
      end else begin
         if (wr_hit && bus_addr == ADDR_W'(REG_CTRL)) begin
            run_q <= bus_wdata[0];
            h12_q <= bus_wdata[1];
         end
         if (wr_hit && bus_addr == ADDR_W'(REG_IEN)) ien_q <= bus_wdata[0];
         evt_q <= (evt_q & ~evt_clr) | evt_set;
      end
   end

   always_comb begin
      bus_rdata = 8'h00;
      for (int i = 0; i < NUM_FIELDS; i++)
         if (bus_addr == ADDR_W'(i)) bus_rdata = vals[i];
      if (bus_addr == ADDR_W'(REG_CTRL)) bus_rdata = {6'b0, h12_q, run_q};
      if (bus_addr == ADDR_W'(REG_STAT)) bus_rdata = {2'b0, evt_q, run_q, busy};
      if (bus_addr == ADDR_W'(REG_IEN))  bus_rdata = {7'b0, ien_q};
   end

   assign irq_timer = ien_q && evt_q[0];

   // R2: a stopped clock with no load keeps its seconds
   p_hold_when_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !load_v[IDX_SEC]) |=> $stable(vals[IDX_SEC]));

   // R7: flags not cleared this cycle survive into the next
   p_sticky_events_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & $past(evt_q & ~evt_clr)) == $past(evt_q & ~evt_clr)));

   // R9: while running, the time fields never take a bus load
   p_no_load_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && wr_hit && bus_addr == ADDR_W'(IDX_MIN) && !inc_v[IDX_MIN]) |=> $stable(vals[IDX_MIN]));
endmodule

// File: tb/bcd_rtc_core_bench.sv
`timescale 1ns/1ps
module bcd_rtc_core_bench;
   localparam int PB = 2;
   localparam int TPS = 1 << PB;
   localparam int NV = 14;

   logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic irq_timer;
   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   bcd_rtc_core #(.PRESCALE_BITS(PB), .ADDR_W(4)) u_bcd_rtc_core (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_timer(irq_timer));

   // {load sec,min,hr,day,mon,yr,wday, expected sec,min,hr,day,mon,yr,wday}
   localparam logic [111:0] VEC [NV] = '{
      {8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00, 8'h01,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00},
      {8'h59,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00, 8'h00,8'h01,8'h00,8'h01,8'h01,8'h00,8'h00},
      {8'h59,8'h59,8'h00,8'h01,8'h01,8'h00,8'h00, 8'h00,8'h00,8'h01,8'h01,8'h01,8'h00,8'h00},
      {8'h59,8'h59,8'h23,8'h15,8'h03,8'h24,8'h02, 8'h00,8'h00,8'h00,8'h16,8'h03,8'h24,8'h03},
      {8'h59,8'h59,8'h23,8'h30,8'h04,8'h24,8'h06, 8'h00,8'h00,8'h00,8'h01,8'h05,8'h24,8'h00},
      {8'h59,8'h59,8'h23,8'h31,8'h05,8'h24,8'h01, 8'h00,8'h00,8'h00,8'h01,8'h06,8'h24,8'h02},
      {8'h59,8'h59,8'h23,8'h28,8'h02,8'h23,8'h00, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h23,8'h01},
      {8'h59,8'h59,8'h23,8'h28,8'h02,8'h24,8'h00, 8'h00,8'h00,8'h00,8'h29,8'h02,8'h24,8'h01},
      {8'h59,8'h59,8'h23,8'h29,8'h02,8'h00,8'h05, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h00,8'h06},
      {8'h59,8'h59,8'h23,8'h31,8'h12,8'h99,8'h06, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00},
      {8'h59,8'h59,8'h23,8'h28,8'h02,8'h12,8'h03, 8'h00,8'h00,8'h00,8'h29,8'h02,8'h12,8'h04},
      {8'h59,8'h59,8'h23,8'h28,8'h02,8'h10,8'h03, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h10,8'h04},
      {8'h59,8'h59,8'h23,8'h30,8'h11,8'h17,8'h04, 8'h00,8'h00,8'h00,8'h01,8'h12,8'h17,8'h05},
      {8'h09,8'h19,8'h09,8'h09,8'h09,8'h09,8'h00, 8'h10,8'h19,8'h09,8'h09,8'h09,8'h09,8'h00}};

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = 4'(a);
      #1 d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) tick_en = 1'b1;
         @(negedge clk) tick_en = 1'b0;
      end
   endtask

   task automatic load_all(input logic [55:0] f);
      for (int k = 0; k < 7; k++) wr(k, f[55-8*k -: 8]);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] rst_exp [7] = '{8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int k = 0; k < 7; k++) begin rd(k, d); chk("R1 field", d, rst_exp[k]); end
      rd(8, d); chk("R1 ctrl", d, 8'h00);
      rd(9, d); chk("R1 status", d, 8'h00);
      chk("R1 irq", {7'b0, irq_timer}, 8'h00);

      // vector table: load while stopped, run one second, stop, compare
      for (int v = 0; v < NV; v++) begin
         load_all(VEC[v][111:56]);
         wr(8, 8'h01);
         ticks(TPS);
         wr(8, 8'h00);
         for (int k = 0; k < 7; k++) begin
            rd(k, d);
            if (k < 3)       chk($sformatf("R3 vec%0d f%0d", v, k), d, VEC[v][55-8*k -: 8]);
            else if (k < 6)  chk($sformatf("R4 vec%0d f%0d", v, k), d, VEC[v][55-8*k -: 8]);
            else             chk($sformatf("R5 vec%0d wday", v), d, VEC[v][55-8*k -: 8]);
         end
      end

      // R2 / R6: busy window and tick counting
      load_all({8'h10,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00});
      ticks(TPS);
      rd(0, d); chk("R2 stopped ignores ticks", d, 8'h10);
      rd(9, d); chk("R6 no busy when stopped", d & 8'h03, 8'h00);
      wr(9, 8'h3C);
      wr(8, 8'h01);
      rd(9, d); chk("R6 run mirrored, not busy", d & 8'h03, 8'h02);
      ticks(TPS - 1);
      rd(0, d); chk("R2 no advance before full second", d, 8'h10);
      rd(9, d); chk("R6 busy before update", d & 8'h03, 8'h03);
      ticks(1);
      rd(0, d); chk("R2 advance after full second", d, 8'h11);
      rd(9, d); chk("R6 busy cleared after update", d & 8'h03, 8'h02);

      // R9 write while running is ignored
      wr(0, 8'h33);
      rd(0, d); chk("R9 running write ignored", d, 8'h11);
      wr(8, 8'h00);
      wr(0, 8'h33);
      rd(0, d); chk("R9 stopped write loads", d, 8'h33);

      // R7 event flags
      wr(9, 8'hFF);
      rd(9, d); chk("R7 flags cleared", d, 8'h00);
      load_all({8'h59,8'h59,8'h23,8'h05,8'h07,8'h30,8'h02});
      wr(8, 8'h01); ticks(TPS); wr(8, 8'h00);
      rd(9, d); chk("R7 all events set", d, 8'h3C);
      wr(9, 8'h04);
      rd(9, d); chk("R7 clear second only", d, 8'h38);
      wr(9, 8'h00);
      rd(9, d); chk("R7 write zero keeps", d, 8'h38);

      // R8 interrupt gating
      wr(9, 8'hFF);
      wr(8, 8'h01); ticks(TPS); wr(8, 8'h00);
      chk("R8 irq masked", {7'b0, irq_timer}, 8'h00);
      wr(10, 8'h01);
      @(negedge clk); chk("R8 irq enabled", {7'b0, irq_timer}, 8'h01);
      wr(9, 8'h04);
      @(negedge clk); chk("R8 irq after clear", {7'b0, irq_timer}, 8'h00);

      // R10 hour-format bit stored, counting stays 24-hour
      load_all({8'h59,8'h59,8'h12,8'h05,8'h07,8'h30,8'h02});
      wr(8, 8'h03);
      rd(8, d); chk("R10 ctrl readback", d, 8'h03);
      ticks(TPS); wr(8, 8'h02);
      rd(2, d); chk("R10 hours 12 to 13", d, 8'h13);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule